// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache Lookup

This unit is the lookup stage of a small direct-mapped read/write data cache for a 32-bit virtual address space. Each request selects its cache line from address bits that translation never changes. In the same cycle, an eight-entry fully associative translation buffer turns the virtual page number into a physical page number. The stored physical tag is then compared against that physical page number, so the hit decision needs no translation step ahead of the array read.

Pages are 4 KB and lines are 16 bytes. Lines are selected by bits [11:4], and these bits lie wholly inside the page offset. Two virtual pages that map to the same physical page therefore share a single cache line, and no alias copy can form. Tags are physical, so lines that belong to different address spaces can sit in the cache together without a flush.

Writes are write-through with no allocation. A read miss with a valid translation asks memory for one 128-bit line. When the line arrives it is written into the arrays and the lookup is replayed. Translation entries come in through a fill port.

Top module: `vipt_dcache`

## Requirements
- R1: A synchronous reset invalidates every cache line and every translation entry. Directly after reset `req_ready` is 1, and `rsp_valid` and `refill_req` are 0.
- R2: When the virtual page has no valid translation, the response has `rsp_xmiss`=1, `rsp_hit`=0 and `rsp_fault`=0. No refill is requested and no write-through is issued. This holds even when the indexed line holds a valid tag.
- R3: A read with a valid translation whose line is invalid, or whose line tag differs from the physical page number, raises `refill_req`. The request carries `refill_paddr` = {PPN, vaddr[11:4], 4'b0000}. Both stay steady until a `refill_valid` beat arrives. The line is then written and the access is replayed, and the read completes with `rsp_hit`=1.
- R4: A read hit returns `rsp_rdata` equal to the 32-bit word vaddr[3:2] of the line. Word n sits at line bits [32n+31:32n]. The response appears one cycle after the request is accepted.
- R5: Two virtual pages mapped to one physical page hit the same line. After a line has been filled through one of them, a read through the other hits without a refill.
- R6: A line tagged with one physical page misses when the same index is read through a page that translates to a different physical page.
- R7: A write on a writable page issues `wt_valid` together with the response. It carries `wt_paddr` = {PPN, vaddr[11:0]} and the write data and strobe. On a hit, only the bytes whose `req_wstrb` bit is set (bit b is byte b of the word) change in the line, and `rsp_hit`=1.
- R8: A write miss allocates nothing. It reports `rsp_hit`=0, still issues the write-through, and the next read of that line misses.
- R9: A write to a page whose writable flag is clear reports `rsp_fault`=1 and `rsp_hit`=0. It issues no write-through and leaves the line unchanged.
- R10: A translation fill whose virtual page is already present overwrites that entry. Any other fill takes the round-robin slot, so the ninth distinct fill after reset evicts the first entry.
- R11: Only one request is in flight at a time. `req_ready` is 0 from acceptance until the response, including the whole refill wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data word |
| req_wstrb | input | 4 | Byte strobes for writes |
| tf_valid | input | 1 | Load a translation entry |
| tf_vpn | input | 20 | Virtual page number to load |
| tf_ppn | input | 20 | Physical page number to load |
| tf_writable | input | 1 | Page may be written |
| refill_req | output | 1 | Line fetch request to memory |
| refill_paddr | output | 32 | Physical line address of fetch |
| refill_valid | input | 1 | Refill beat present |
| refill_data | input | 128 | Whole line returned by memory |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_rdata | output | 32 | Read word (0 for writes and misses) |
| rsp_hit | output | 1 | Cache hit |
| rsp_xmiss | output | 1 | No translation for the page |
| rsp_fault | output | 1 | Write to a read-only page |
| wt_valid | output | 1 | Write-through to memory |
| wt_paddr | output | 32 | Physical byte address of write-through |
| wt_data | output | 32 | Write-through data |
| wt_strb | output | 4 | Write-through strobes |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 4 KB pages, 16-byte lines and an 8-entry translation buffer. With these values the index is 8 bits wide and the whole of it sits inside the page offset. Random traffic is confined to a few line indices and a small pool of virtual pages, which makes several pages map to one physical page and several physical pages compete for one line. Those are the alias, tag-conflict and eviction cases. Because the buffer has only eight slots, round-robin eviction can be reached with a handful of fills.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_FILL = 2'd1,
    ST_RERD = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_xlate.sv
module vc_xlate #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  output logic             look_wr
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     ent_v, ent_w, look_m, fill_m;
  logic [VPN_W-1:0] ent_vpn [N];
  logic [PPN_W-1:0] ent_ppn [N];
  logic [PW-1:0]    ptr, fidx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign look_m[g] = ent_v[g] && (ent_vpn[g] == look_vpn);
    assign fill_m[g] = ent_v[g] && (ent_vpn[g] == fill_vpn);
  end

  always_comb begin
    look_ppn = '0;
    look_wr  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (look_m[i]) begin
        look_ppn = look_ppn | ent_ppn[i];
        look_wr  = look_wr | ent_w[i];
      end
    end
  end
  assign look_hit = |look_m;

  always_comb begin
    fidx = ptr;
    for (int i = 0; i < N; i++) begin
      if (fill_m[i]) fidx = PW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      ent_w <= '0;
      ptr   <= '0;
    end else if (fill_en) begin
      ent_v[fidx]   <= 1'b1;
      ent_w[fidx]   <= fill_wr;
      ent_vpn[fidx] <= fill_vpn;
      ent_ppn[fidx] <= fill_ppn;
      if (!(|fill_m)) ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W+LINE_W-1:0] ram [DEPTH];
  logic [TAG_W+LINE_W-1:0] rd_word;
  logic [DEPTH-1:0]        vbits;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_line};
    if (rd_en) rd_word <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vbits[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= vbits[rd_idx];
    end
  end

  assign rd_tag  = rd_word[TAG_W+LINE_W-1:LINE_W];
  assign rd_line = rd_word[LINE_W-1:0];
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int OFS_W  = 4,
  parameter int WORD_W = 32,
  parameter int TLB_N  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [WORD_W-1:0]        req_wdata,
  input  logic [WORD_W/8-1:0]      req_wstrb,
  input  logic                     tf_valid,
  input  logic [VA_W-PAGE_W-1:0]   tf_vpn,
  input  logic [VA_W-PAGE_W-1:0]   tf_ppn,
  input  logic                     tf_writable,
  output logic                     refill_req,
  output logic [VA_W-1:0]          refill_paddr,
  input  logic                     refill_valid,
  input  logic [(8<<OFS_W)-1:0]    refill_data,
  output logic                     rsp_valid,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic                     rsp_hit,
  output logic                     rsp_xmiss,
  output logic                     rsp_fault,
  output logic                     wt_valid,
  output logic [VA_W-1:0]          wt_paddr,
  output logic [WORD_W-1:0]        wt_data,
  output logic [WORD_W/8-1:0]      wt_strb
);
  localparam int PN_W   = VA_W - PAGE_W;
  localparam int IDX_W  = PAGE_W - OFS_W;
  localparam int LINE_W = 8 << OFS_W;
  localparam int STRB_W = WORD_W / 8;
  localparam int BSEL_W = $clog2(STRB_W);
  localparam int WSEL_W = OFS_W - BSEL_W;

  vc_state_e            state;
  logic                 s1_valid, s1_write;
  logic [VA_W-1:0]      s1_va;
  logic [WORD_W-1:0]    s1_wdata;
  logic [STRB_W-1:0]    s1_strb;

  logic                 accept, eval, finish, do_miss, wr_ok, c_hit;
  logic                 t_hit, t_wr;
  logic [PN_W-1:0]      t_ppn;
  logic                 rd_en, rd_valid, st_we;
  logic [IDX_W-1:0]     rd_idx, s1_idx;
  logic [PN_W-1:0]      rd_tag, st_tag;
  logic [LINE_W-1:0]    rd_line, merged, st_line;
  logic [WSEL_W-1:0]    wsel;
  logic [WORD_W-1:0]    rd_word;

  assign req_ready = !s1_valid;
  assign accept    = req_valid && !s1_valid;
  assign s1_idx    = s1_va[PAGE_W-1:OFS_W];
  assign wsel      = s1_va[OFS_W-1:BSEL_W];
  assign rd_en     = accept || (state == ST_RERD);
  assign rd_idx    = (state == ST_RERD) ? s1_idx : req_vaddr[PAGE_W-1:OFS_W];

  vc_xlate #(.N(TLB_N), .VPN_W(PN_W), .PPN_W(PN_W)) u_xlate (
    .clk(clk), .rst(rst),
    .fill_en(tf_valid), .fill_vpn(tf_vpn), .fill_ppn(tf_ppn), .fill_wr(tf_writable),
    .look_vpn(s1_va[VA_W-1:PAGE_W]),
    .look_hit(t_hit), .look_ppn(t_ppn), .look_wr(t_wr)
  );

  vc_store #(.IDX_W(IDX_W), .TAG_W(PN_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(st_we), .wr_idx(s1_idx), .wr_tag(st_tag), .wr_line(st_line),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line)
  );

  assign eval    = s1_valid && (state == ST_LOOK);
  assign c_hit   = rd_valid && (rd_tag == t_ppn);
  assign do_miss = eval && t_hit && !s1_write && !c_hit;
  assign wr_ok   = eval && t_hit && s1_write && t_wr;
  assign finish  = eval && !do_miss;
  assign rd_word = rd_line[wsel*WORD_W +: WORD_W];

  always_comb begin
    merged = rd_line;
    for (int b = 0; b < STRB_W; b++) begin
      if (s1_strb[b]) merged[wsel*WORD_W + b*8 +: 8] = s1_wdata[b*8 +: 8];
    end
  end

  assign st_we   = ((state == ST_FILL) && refill_valid) || (wr_ok && c_hit);
  assign st_tag  = (state == ST_FILL) ? refill_paddr[VA_W-1:PAGE_W] : t_ppn;
  assign st_line = (state == ST_FILL) ? refill_data : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_LOOK;
      s1_valid     <= 1'b0;
      s1_write     <= 1'b0;
      s1_va        <= '0;
      s1_wdata     <= '0;
      s1_strb      <= '0;
      refill_req   <= 1'b0;
      refill_paddr <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_hit      <= 1'b0;
      rsp_xmiss    <= 1'b0;
      rsp_fault    <= 1'b0;
      wt_valid     <= 1'b0;
      wt_paddr     <= '0;
      wt_data      <= '0;
      wt_strb      <= '0;
    end else begin
      rsp_valid <= finish;
      wt_valid  <= wr_ok;
      if (accept) begin
        s1_valid <= 1'b1;
        s1_write <= req_write;
        s1_va    <= req_vaddr;
        s1_wdata <= req_wdata;
        s1_strb  <= req_wstrb;
      end else if (finish) begin
        s1_valid <= 1'b0;
      end
      if (finish) begin
        rsp_hit   <= t_hit && (!s1_write || t_wr) && c_hit;
        rsp_xmiss <= !t_hit;
        rsp_fault <= t_hit && s1_write && !t_wr;
        rsp_rdata <= (t_hit && !s1_write && c_hit) ? rd_word : '0;
      end
      if (wr_ok) begin
        wt_paddr <= {t_ppn, s1_va[PAGE_W-1:0]};
        wt_data  <= s1_wdata;
        wt_strb  <= s1_strb;
      end
      case (state)
        ST_LOOK: if (do_miss) begin
          state        <= ST_FILL;
          refill_req   <= 1'b1;
          refill_paddr <= {t_ppn, s1_idx, {OFS_W{1'b0}}};
        end
        ST_FILL: if (refill_valid) begin
          refill_req <= 1'b0;
          state      <= ST_RERD;
        end
        default: state <= ST_LOOK;
      endcase
    end
  end
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            refill_req,
  input logic            refill_valid,
  input logic [VA_W-1:0] refill_paddr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_xmiss,
  input logic            rsp_fault,
  input logic            wt_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !refill_req));

  assert_xmiss_excl_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_xmiss) |-> (!rsp_hit && !rsp_fault));

  assert_refill_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_paddr)));

  assert_refill_align_R3: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (refill_paddr[OFS_W-1:0] == '0));

  assert_fault_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (!wt_valid && !rsp_hit));

  assert_busy_refill_R11: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> !req_ready);

  assert_rsp_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !$past(req_ready));
endmodule

bind vipt_dcache vipt_dcache_chk #(.VA_W(VA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .refill_req(refill_req), .refill_valid(refill_valid), .refill_paddr(refill_paddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_xmiss(rsp_xmiss),
  .rsp_fault(rsp_fault), .wt_valid(wt_valid)
);

// File: tb/sim_vipt_dcache.sv
module sim_vipt_dcache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_vaddr = '0, req_wdata = '0;
  logic [3:0]   req_wstrb = '0;
  logic         tf_valid = 1'b0, tf_writable = 1'b0;
  logic [19:0]  tf_vpn = '0, tf_ppn = '0;
  logic         refill_valid = 1'b0;
  logic [127:0] refill_data = '0;
  logic         req_ready, refill_req, rsp_valid, rsp_hit, rsp_xmiss, rsp_fault, wt_valid;
  logic [31:0]  refill_paddr, rsp_rdata, wt_paddr, wt_data;
  logic [3:0]   wt_strb;

  always #4 clk = ~clk;

  vipt_dcache u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .tf_valid(tf_valid), .tf_vpn(tf_vpn), .tf_ppn(tf_ppn), .tf_writable(tf_writable),
    .refill_req(refill_req), .refill_paddr(refill_paddr),
    .refill_valid(refill_valid), .refill_data(refill_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .rsp_xmiss(rsp_xmiss), .rsp_fault(rsp_fault),
    .wt_valid(wt_valid), .wt_paddr(wt_paddr), .wt_data(wt_data), .wt_strb(wt_strb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit           m_tv [8];
  bit           m_tw [8];
  logic [19:0]  m_tvpn [8];
  logic [19:0]  m_tppn [8];
  int           m_ptr = 0;
  bit           m_lv [256];
  logic [19:0]  m_tag [256];
  logic [127:0] m_dat [256];

  // observed results of the last access
  bit           r_hit, r_x, r_f, r_wtv, saw_ref;
  logic [31:0]  r_rd, r_wa, r_wd, r_rp;
  logic [3:0]   r_ws;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] line_data(input logic [31:0] pa);
    logic [127:0] d;
    for (int i = 0; i < 4; i++) d[i*32 +: 32] = {pa[31:4], 2'(i), 2'b00} ^ 32'h5A3C_0F00;
    return d;
  endfunction

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit w);
    int slot;
    bit found;
    @(negedge clk);
    tf_valid = 1'b1; tf_vpn = vpn; tf_ppn = ppn; tf_writable = w;
    @(negedge clk);
    tf_valid = 1'b0;
    found = 0; slot = m_ptr;
    for (int i = 0; i < 8; i++) if (m_tv[i] && m_tvpn[i] == vpn) begin found = 1; slot = i; end
    m_tv[slot] = 1; m_tw[slot] = w; m_tvpn[slot] = vpn; m_tppn[slot] = ppn;
    if (!found) m_ptr = (m_ptr + 1) % 8;
  endtask

  task automatic dut_access(input bit w, input logic [31:0] va, input logic [31:0] wd, input logic [3:0] st);
    int n;
    bit got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vaddr = va; req_wdata = wd; req_wstrb = st;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; n = 0; saw_ref = 0;
    while (!got && n < 200) begin
      if (rsp_valid) begin
        got = 1;
        r_hit = rsp_hit; r_x = rsp_xmiss; r_f = rsp_fault; r_rd = rsp_rdata;
        r_wtv = wt_valid; r_wa = wt_paddr; r_wd = wt_data; r_ws = wt_strb;
      end else if (refill_req) begin
        saw_ref = 1; r_rp = refill_paddr;
        chk(!req_ready, "R11 ready low during refill", req_ready, 0);
        refill_valid = 1'b1; refill_data = line_data(refill_paddr);
        @(negedge clk);
        refill_valid = 1'b0;
        n++;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    if (!got) chk(0, "R11 response timeout", n, 0);
  endtask

  // model the access, run it on the DUT, compare everything
  task automatic access(input bit w, input logic [31:0] va, input logic [31:0] wd, input logic [3:0] st);
    bit th, pw, e_f, e_ref, e_wt, chit, e_hit;
    logic [19:0] pp;
    logic [7:0] idx;
    logic [1:0] ws;
    logic [31:0] e_rp, e_rd;
    th = 0; pw = 0; pp = '0;
    for (int i = 0; i < 8; i++) if (m_tv[i] && m_tvpn[i] == va[31:12]) begin th = 1; pp = m_tppn[i]; pw = m_tw[i]; end
    idx = va[11:4]; ws = va[3:2];
    e_f   = th && w && !pw;
    e_wt  = th && w && pw;
    e_ref = th && !w && !(m_lv[idx] && m_tag[idx] == pp);
    e_rp  = {pp, idx, 4'h0};
    if (e_ref) begin m_lv[idx] = 1; m_tag[idx] = pp; m_dat[idx] = line_data(e_rp); end
    chit  = th && m_lv[idx] && m_tag[idx] == pp;
    e_hit = chit && !e_f;
    e_rd  = (th && !w && chit) ? m_dat[idx][ws*32 +: 32] : 32'h0;
    if (e_wt && chit) for (int b = 0; b < 4; b++) if (st[b]) m_dat[idx][ws*32 + b*8 +: 8] = wd[b*8 +: 8];
    dut_access(w, va, wd, st);
    chk(r_x == !th, "R2 xmiss", r_x, !th);
    chk(r_f == e_f, "R9 fault", r_f, e_f);
    chk(r_hit == e_hit, "R4 hit", r_hit, e_hit);
    if (!w) chk(r_rd == e_rd, "R4 read data", r_rd, e_rd);
    chk(saw_ref == e_ref, "R3 refill request", saw_ref, e_ref);
    if (e_ref) chk(r_rp == e_rp, "R3 refill address", r_rp, e_rp);
    chk(r_wtv == e_wt, "R7 write-through valid", r_wtv, e_wt);
    if (e_wt) chk({r_wa, r_wd, r_ws} == {pp, va[11:0], wd, st}, "R7 write-through fields",
                  {r_wa, r_wd, r_ws}, {pp, va[11:0], wd, st});
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) m_tv[i] = 0;
    for (int i = 0; i < 256; i++) m_lv[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !refill_req, "R1 reset state", {req_ready, rsp_valid, refill_req}, 3'b100);
    access(0, 32'h0000_1234, 0, 0);                       // R1/R2 empty translation buffer
    chk(r_x, "R1 no translation after reset", r_x, 1);
    fill(20'h00001, 20'h00080, 1);
    access(0, 32'h0000_1234, 0, 0);                       // R1 lines invalid, R3 refill
    chk(saw_ref && r_hit, "R3 miss then replay hit", {saw_ref, r_hit}, 2'b11);
    access(0, 32'h0000_1238, 0, 0);                       // R4 hit
    fill(20'h7FFFF, 20'h00080, 0);
    access(0, 32'h7FFF_F238, 0, 0);                       // R5 alias shares line
    chk(!saw_ref && r_hit, "R5 alias hit without refill", {saw_ref, r_hit}, 2'b01);
    access(1, 32'h7FFF_F238, 32'hDEAD_BEEF, 4'hF);        // R9 read-only page
    chk(r_f && !r_wtv, "R9 fault without write-through", {r_f, r_wtv}, 2'b10);
    access(0, 32'h0000_1238, 0, 0);                       // R9 line unchanged
    access(1, 32'h0000_1238, 32'hCAFE_F00D, 4'b0101);     // R7 partial write hit
    access(0, 32'h7FFF_F238, 0, 0);                       // R7 merged bytes via alias
    access(1, 32'h0000_1544, 32'h1357_9BDF, 4'hF);        // R8 write miss
    chk(!r_hit && r_wtv, "R8 write miss goes through", {r_hit, r_wtv}, 2'b01);
    access(0, 32'h0000_1544, 0, 0);
    chk(saw_ref, "R8 no allocation on write miss", saw_ref, 1);
    fill(20'h00002, 20'h00090, 1);
    access(0, 32'h0000_2234, 0, 0);                       // R6 tag conflict
    chk(saw_ref, "R6 different physical page misses", saw_ref, 1);
    access(0, 32'h0000_3234, 0, 0);                       // R2 valid line, no translation
    chk(r_x && !saw_ref, "R2 xmiss despite valid line", {r_x, saw_ref}, 2'b10);
    fill(20'h00001, 20'h00091, 1);                        // R10 replace in place
    access(0, 32'h0000_1234, 0, 0);
    chk(r_rp == 32'h0009_1230, "R10 replaced entry used", r_rp, 32'h0009_1230);
    for (int v = 0; v < 6; v++) fill(20'h00010 + 20'(v), 20'h000A0, 1);
    access(0, 32'h0000_1234, 0, 0);
    chk(r_x, "R10 round-robin evicts oldest", r_x, 1);
    access(0, 32'h7FFF_F234, 0, 0);
    chk(!r_x, "R10 newer entry kept", r_x, 0);
    // constrained random traffic
    for (int k = 0; k < 600; k++) begin
      logic [19:0] pool [6];
      logic [19:0] ppns [4];
      logic [7:0]  idxs [4];
      int r;
      pool = '{20'h00001, 20'h00002, 20'h00003, 20'h7FFFF, 20'h00010, 20'h00015};
      ppns = '{20'h00080, 20'h00090, 20'h00091, 20'h000A0};
      idxs = '{8'h23, 8'h54, 8'h10, 8'h11};
      r = $urandom % 16;
      if (r < 2) fill(pool[$urandom % 6], ppns[$urandom % 4], 1'($urandom % 4 != 0));
      else access(r < 7, {pool[$urandom % 6], idxs[$urandom % 4], 4'($urandom % 16)},
                  $urandom, 4'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule